// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a slave port that gives an external microprocessor read and write access to an internal bank of 8-bit registers over a four-wire serial link. The four wires are an active-low chip select, a serial clock, a serial data input and a serial data output. Every access is one frame of sixteen serial clock cycles. The frame carries a direction bit, a 7-bit register address and one data byte, and every field travels least significant bit first.

The serial pins are sampled by a faster system clock. Each pin passes through a two-stage synchronizer, and the clock edges are found by comparing the synchronized level with its value one system cycle earlier. On the register side the block drives an address, write data, a one-cycle write strobe and a one-cycle read strobe, and it takes read data back from the bank. A static edge-select input decides whether the read data on the serial output changes after rising or after falling serial clock edges. While chip select is high, the serial output is not driven; this is modelled as an output-enable that is low.

Top module: `sreg_slave`

## Requirements
- R1: After reset, sdo_o, sdo_oe_o, reg_we_o and reg_re_o are all 0.
- R2: While cs_n_i is low, a bit is taken from sdi_i on each rising edge of sck_i. Bit 0 of the frame is the direction bit (1 = read, 0 = write). Bits 1 to 7 carry address bits A0 to A6, and bits 8 to 15 carry data bits D0 to D7, least significant bit first.
- R3: A write frame gives exactly one reg_we_o pulse, one system cycle wide, after its 16th bit has been sampled. While reg_we_o is high, reg_addr_o holds the frame's address and reg_wdata_o holds its data byte.
- R4: If cs_n_i rises before the 16th bit of a write frame, no write strobe is issued and no register changes.
- R5: A read frame gives exactly one reg_re_o pulse, one system cycle wide, after its 8th bit (A6) has been sampled, with reg_addr_o holding the address. reg_rdata_i is captured in that same cycle.
- R6: In a read, D0 to D7 of the captured byte appear on sdo_o in that order, with sdo_oe_o high. With edge_sel_i = 0, bit Dk is launched after rising edge number 8+k of the frame, counting from 1. With edge_sel_i = 1, bit Dk is launched after the falling edge that follows that rising edge.
- R7: While chip select is high, sdo_oe_o is 0 and sdo_o reads 0. Both are released within four system cycles after cs_n_i rises.
- R8: Raising cs_n_i returns the bit count to zero, so the next frame decodes correctly whatever came before. Serial clock edges seen while cs_n_i is high have no effect.
- R9: Bits after the 16th in the same frame are ignored: no second strobe is issued and the written byte is unchanged.
- R10: A write frame never raises reg_re_o, a read frame never raises reg_we_o, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data from the master |
| edge_sel_i | input | 1 | Read data launch edge: 0 = after rising edges, 1 = after falling edges |
| sdo_o | output | 1 | Serial read data; 0 when not driven |
| sdo_oe_o | output | 1 | High while sdo_o is driven |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | DATA_W | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | DATA_W | Read data from the register bank, valid while reg_re_o is high |

## Verification
The bench builds the block with its defaults: a 7-bit address, 8-bit data and two synchronizer stages. This makes all 128 register addresses and every byte value reachable, and the bench models the full register bank. It drives the serial clock at sixteen system cycles per period, which leaves room for the synchronizer and edge-detect latency between each serial edge and the point where the output is sampled. Both launch edges are exercised, as are writes cut short, frames longer than sixteen bits and clock toggling while chip select is high.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    // Direction bit carried first in every frame
    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_e;

    // Raw or synchronized serial pins
    typedef struct packed {
        logic cs_n;
        logic sck;
        logic sdi;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0};

    // Per-cycle serial events after edge detection
    typedef struct packed {
        logic rise;   // sck rising while selected
        logic fall;   // sck falling while selected
        logic idle;   // chip select inactive
        logic sdi;    // synchronized data level
    } evt_t;

    function automatic int frame_len(input int aw, input int dw);
        return 1 + aw + dw;
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sreg_edge.sv
module sreg_edge
    import sreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t s,
    output evt_t  ev
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= s.sck;
    end

    assign ev.rise = s.sck & ~sck_q & ~s.cs_n;
    assign ev.fall = ~s.sck & sck_q & ~s.cs_n;
    assign ev.idle = s.cs_n;
    assign ev.sdi  = s.sdi;
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              ev,
    output logic [CNT_W-1:0]  cnt,
    output dir_e              dir,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              re,
    output logic              we
);
    localparam int               FRAME_BITS = frame_len(ADDR_W, DATA_W);
    localparam logic [CNT_W-1:0] C_LAST_A   = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] C_FULL     = CNT_W'(FRAME_BITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            dir  <= DIR_WR;
            addr <= '0;
            data <= '0;
            re   <= 1'b0;
            we   <= 1'b0;
        end else begin
            re <= 1'b0;
            we <= 1'b0;
            if (ev.idle) begin
                cnt <= '0;
            end else if (ev.rise && cnt < C_FULL) begin
                cnt <= cnt + 1'b1;
                if (cnt == '0)
                    dir <= dir_e'(ev.sdi);
                else if (cnt <= C_LAST_A)
                    addr <= {ev.sdi, addr[ADDR_W-1:1]};
                else
                    data <= {ev.sdi, data[DATA_W-1:1]};
                if (cnt == C_LAST_A && dir == DIR_RD) re <= 1'b1;
                if (cnt == C_LAST   && dir == DIR_WR) we <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sreg_sdo.sv
module sreg_sdo
    import sreg_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              ev,
    input  logic              edge_sel,
    input  logic [CNT_W-1:0]  cnt,
    input  dir_e              dir,
    input  logic              re,
    input  logic [DATA_W-1:0] rdata,
    output logic              sdo,
    output logic              oe
);
    localparam int               FRAME_BITS = frame_len(ADDR_W, DATA_W);
    localparam logic [CNT_W-1:0] C_D1       = CNT_W'(ADDR_W + 1);
    localparam logic [CNT_W-1:0] C_RISE_END = CNT_W'(FRAME_BITS - 2);
    localparam logic [CNT_W-1:0] C_FALL_END = CNT_W'(FRAME_BITS - 1);

    logic [DATA_W-1:0] rsh;
    logic              rise_go;
    logic              fall_go;

    // Rising mode: D0 leaves with the read strobe, D1..D7 on later rises.
    // Falling mode: D0..D7 on the falls after the address is complete.
    assign rise_go = !edge_sel && ev.rise && dir == DIR_RD &&
                     cnt >= C_D1 && cnt <= C_RISE_END;
    assign fall_go = edge_sel && ev.fall && dir == DIR_RD &&
                     cnt >= C_D1 && cnt <= C_FALL_END;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsh <= '0;
            sdo <= 1'b0;
            oe  <= 1'b0;
        end else if (ev.idle) begin
            sdo <= 1'b0;
            oe  <= 1'b0;
        end else if (re) begin
            if (edge_sel) begin
                rsh <= rdata;
            end else begin
                rsh <= rdata >> 1;
                sdo <= rdata[0];
                oe  <= 1'b1;
            end
        end else if (rise_go || fall_go) begin
            sdo <= rsh[0];
            rsh <= rsh >> 1;
            oe  <= 1'b1;
        end
    end
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
    import sreg_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              edge_sel_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int PIN_W = $bits(pins_t);
    localparam int CNT_W = $clog2(frame_len(ADDR_W, DATA_W) + 1);

    pins_t             raw;
    pins_t             syn;
    evt_t              ev;
    logic [CNT_W-1:0]  cnt;
    dir_e              dir;

    assign raw = '{cs_n: cs_n_i, sck: sck_i, sdi: sdi_i};

    sreg_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw),
        .q  (syn)
    );

    sreg_edge u_edge (
        .clk(clk),
        .rst(rst),
        .s  (syn),
        .ev (ev)
    );

    sreg_frame #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_frame (
        .clk (clk),
        .rst (rst),
        .ev  (ev),
        .cnt (cnt),
        .dir (dir),
        .addr(reg_addr_o),
        .data(reg_wdata_o),
        .re  (reg_re_o),
        .we  (reg_we_o)
    );

    sreg_sdo #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_sdo (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .edge_sel(edge_sel_i),
        .cnt     (cnt),
        .dir     (dir),
        .re      (reg_re_o),
        .rdata   (reg_rdata_i),
        .sdo     (sdo_o),
        .oe      (sdo_oe_o)
    );
endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk (
    input logic clk,
    input logic rst,
    input logic cs_n_i,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic reg_we_o,
    input logic reg_re_o
);
    // R10: strobes are exclusive
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(reg_re_o && reg_we_o));

    // R5: read strobe lasts one cycle
    p_re_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        reg_re_o |=> !reg_re_o);

    // R3: write strobe lasts one cycle
    p_we_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        reg_we_o |=> !reg_we_o);

    // R7: undriven line reads 0
    p_sdo_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe_o |-> !sdo_o);

    // R7: output released after chip select has been high a few cycles
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n_i, 1) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_oe_o);
endmodule

bind sreg_slave sreg_slave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n_i  (cs_n_i),
    .sdo_o   (sdo_o),
    .sdo_oe_o(sdo_oe_o),
    .reg_we_o(reg_we_o),
    .reg_re_o(reg_re_o)
);

// File: tb/sreg_slave_tb.sv
module sreg_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       sdi = 1'b0;
    logic       edge_sel = 1'b0;
    logic       sdo;
    logic       sdo_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic       reg_re;
    logic [7:0] reg_rdata;

    logic [7:0] mem     [128];
    logic [7:0] exp_mem [128];
    int we_cnt = 0;
    int re_cnt = 0;
    logic [6:0] last_wa = '0;
    logic [7:0] last_wd = '0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_slave u_dut (
        .clk        (clk),
        .rst        (rst),
        .cs_n_i     (cs_n),
        .sck_i      (sck),
        .sdi_i      (sdi),
        .edge_sel_i (edge_sel),
        .sdo_o      (sdo),
        .sdo_oe_o   (sdo_oe),
        .reg_addr_o (reg_addr),
        .reg_wdata_o(reg_wdata),
        .reg_we_o   (reg_we),
        .reg_re_o   (reg_re),
        .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];

    // Register bank model driven by the strobes
    always @(posedge clk) begin
        if (!rst && reg_we) begin
            mem[reg_addr] <= reg_wdata;
            last_wa       <= reg_addr;
            last_wd       <= reg_wdata;
            we_cnt        <= we_cnt + 1;
        end
        if (!rst && reg_re) re_cnt <= re_cnt + 1;
    end

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 5) & 8'hFF);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Master frame: nbits clock cycles, returns bits seen on sdo in the data phase
    task automatic run_frame(input bit dir, input logic [6:0] addr, input logic [7:0] wd,
                             input int nbits, output logic [7:0] rd, output int oe_hits);
        rd = '0;
        oe_hits = 0;
        cs_n = 1'b0;
        sck  = 1'b0;
        wait_clk(4 * HALF_SCK);
        for (int i = 0; i < nbits; i++) begin
            if (i == 0)       sdi = dir;
            else if (i <= 7)  sdi = addr[i-1];
            else if (i <= 15) sdi = wd[i-8];
            else              sdi = 1'($urandom % 2);
            wait_clk(HALF_SCK);
            if (!edge_sel && i >= 8 && i <= 15) begin
                rd[i-8] = sdo;
                if (sdo_oe) oe_hits++;
            end
            sck = 1'b1;
            wait_clk(HALF_SCK);
            if (edge_sel && i >= 8 && i <= 15) begin
                rd[i-8] = sdo;
                if (sdo_oe) oe_hits++;
            end
            sck = 1'b0;
        end
        wait_clk(HALF_SCK);
        cs_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic do_write(input string tag, input logic [6:0] a, input logic [7:0] d,
                            input int nbits);
        logic [7:0] rd;
        int oh;
        int w0 = we_cnt;
        int r0 = re_cnt;
        run_frame(1'b0, a, d, nbits, rd, oh);
        if (nbits >= 16) begin
            exp_mem[a] = d;
            check({tag, " R3 write strobe count"}, we_cnt - w0, 1);
            check({tag, " R2 write address"}, int'(last_wa), int'(a));
            check({tag, " R2 write data"}, int'(last_wd), int'(d));
        end else begin
            check({tag, " R4 aborted write strobe count"}, we_cnt - w0, 0);
        end
        check({tag, " R10 no read strobe in write"}, re_cnt - r0, 0);
        check({tag, " R6 no drive in write"}, oh, 0);
    endtask

    task automatic do_read(input string tag, input logic [6:0] a, input int nbits);
        logic [7:0] rd;
        int oh;
        int w0 = we_cnt;
        int r0 = re_cnt;
        run_frame(1'b1, a, 8'($urandom), nbits, rd, oh);
        check({tag, " R5 read strobe count"}, re_cnt - r0, 1);
        check({tag, " R10 no write strobe in read"}, we_cnt - w0, 0);
        check({tag, " R6 read data"}, int'(rd), int'(exp_mem[a]));
        check({tag, " R6 output enabled for all bits"}, oh, 8);
        check({tag, " R7 released after frame oe"}, int'(sdo_oe), 0);
        check({tag, " R7 released after frame sdo"}, int'(sdo), 0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        for (int i = 0; i < 128; i++) begin
            mem[i]     = init_val(i);
            exp_mem[i] = init_val(i);
        end
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);

        // R1 reset state
        check("R1 sdo after reset", int'(sdo), 0);
        check("R1 oe after reset", int'(sdo_oe), 0);
        check("R1 we after reset", int'(reg_we), 0);
        check("R1 re after reset", int'(reg_re), 0);

        // Directed write and readback in both launch modes
        edge_sel = 1'b0;
        do_write("dir_w", 7'h55, 8'hA3, 16);
        do_read("dir_r_rise", 7'h55, 16);
        edge_sel = 1'b1;
        do_read("dir_r_fall", 7'h55, 16);
        do_read("dir_r_fall_top", 7'h7F, 16);
        edge_sel = 1'b0;
        do_read("dir_r_rise_zero", 7'h00, 16);

        // R4 aborted write, then R8 clean next frame
        do_write("abort", 7'h12, 8'h3C, 12);
        do_write("after_abort_R8", 7'h21, 8'h99, 16);
        do_read("abort_untouched_R4", 7'h12, 16);

        // R8 clock toggles while deselected
        for (int i = 0; i < 5; i++) begin
            sck = 1'b1; wait_clk(HALF_SCK);
            check("R7 oe low while deselected", int'(sdo_oe), 0);
            sck = 1'b0; wait_clk(HALF_SCK);
        end
        check("R8 no strobe from deselected clocks", int'(reg_we | reg_re), 0);
        do_write("idle_clk_R8", 7'h0F, 8'h5A, 16);

        // R9 overlong frames
        do_write("long_w_R9", 7'h03, 8'h11, 20);
        edge_sel = 1'b1;
        do_read("long_r_R9", 7'h03, 20);

        // Random frames
        for (int n = 0; n < 40; n++) begin
            logic [6:0] a = 7'($urandom);
            logic [7:0] d = 8'($urandom);
            edge_sel = 1'($urandom % 2);
            if ($urandom % 2) do_read("rand_r", a, 16);
            else              do_write("rand_w", a, d, 16);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule